// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block connects a 32-bit execution core to a data memory that is organised as whole words. For each memory operation the core supplies a base register value, a signed 16-bit displacement, an access size, the store data, a flag that selects zero extension on loads, and a flag that selects the byte numbering within a word. The block forms the effective address and places the memory word address, the per-byte write strobes and the lane-positioned store data on its memory side one clock later.

For loads, the memory returns the whole word one cycle after the read strobe. The block keeps the lane position, size, extension mode and byte order of each load in a short pipeline so that they reach the data when it arrives. It then picks out the addressed byte or halfword and extends it to 32 bits. An access whose address is not a multiple of its size raises a misalignment flag for one cycle. Such an access touches no memory and produces no load result.

Top module: `lsu_lane_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero, and requests presented during reset produce nothing.
- R2: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. `mem_addr` carries that address with bits 1:0 cleared, one cycle after the request.
- R3: With `req_big_endian`=0, the byte at word offset n occupies bits 8n+7..8n of the memory word.
- R4: With `req_big_endian`=1, the byte at word offset n occupies bits 31-8n..24-8n, so offset 0 is the most significant byte.
- R5: A halfword at word offset 0 or 2 uses the lower half (bits 15..0) when address bit 1 is 1 in big-endian order or 0 in little-endian order. Otherwise it uses the upper half (bits 31..16).
- R6: `req_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = word. On an aligned access `mem_be` is one-hot for a byte, 4'b0011 or 4'b1100 for a halfword, and 4'b1111 for a word. Bit i of `mem_be` covers bits 8i+7..8i.
- R7: A store drives `mem_we` for one cycle and places the low 8 or 16 bits of `req_wdata` in the addressed lanes of `mem_wdata`, with zeros in the other lanes. A word store passes `req_wdata` unchanged. Bytes that are not enabled keep their memory contents. `mem_we` and `mem_re` are never high together.
- R8: With `req_unsigned`=0, a byte or halfword load copies the top bit of the selected data into all higher bits of `ld_data`.
- R9: With `req_unsigned`=1, a byte or halfword load fills the higher bits of `ld_data` with zeros. A word load returns the memory word unchanged.
- R10: A halfword with address bit 0 set, or a word with address bits 1:0 not both zero, raises `misalign` for one cycle. It keeps `mem_be`, `mem_we` and `mem_re` at zero, writes no memory and gives no `ld_valid`. A byte access is never misaligned.
- R11: An aligned load raises `mem_re` one cycle after the request and raises `ld_valid` with its result two cycles after `mem_re`. Back-to-back loads produce back-to-back results in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Load zero-extends when 1 |
| req_big_endian | input | 1 | Byte numbering: 1 big-endian, 0 little-endian |
| mem_addr | output | 32 | Word address to memory, low two bits zero |
| mem_be | output | 4 | Byte enables, bit i for bits 8i+7..8i |
| mem_wdata | output | 32 | Lane-positioned store data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 32 | Word returned one cycle after `mem_re` |
| misalign | output | 1 | Request was not aligned to its size |
| ld_valid | output | 1 | Load result is valid |
| ld_data | output | 32 | Extended load result |

## Verification
The memory-side outputs (`mem_addr`, `mem_be`, `mem_wdata`, the strobes and `misalign`) are due in the cycle after the request edge. The load result is due two cycles after that, which allows for the memory's one-cycle read. The bench tags every expectation with its due cycle when it issues the request. At each falling edge it compares the head of each queue only in the cycle it is due, and in every other cycle it requires the strobes, `misalign` and `ld_valid` to be low. A load issued right after a store to the same word reads the written value, because the store's write edge comes before the load's read edge. The bench's reference byte model is therefore updated in program order.

// File: rtl/lsu_pkg.sv
// Shared types for the load/store lane unit.
// Assumes a data word made of 8-bit lanes.
package lsu_pkg;

    // Access width code as carried on the request port.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

endpackage

// File: rtl/lsu_agen.sv
// Effective-address generator.
// Adds the sign-extended displacement to the base and flags an address
// that is not a multiple of the access width. Purely combinational.
module lsu_agen #(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  logic [XLEN-1:0]     base,
    input  logic [OFFW-1:0]     offset,
    input  lsu_pkg::size_e      size,
    output logic [XLEN-1:0]     ea,
    output logic                misaligned
);
    localparam int LANES = XLEN / 8;
    localparam int AW    = $clog2(LANES);

    // Sum of base and sign-extended displacement.
    always_comb begin
        ea = base + {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
    end

    // Alignment test against the access width.
    always_comb begin
        unique case (size)
            lsu_pkg::SZ_BYTE: misaligned = 1'b0;
            lsu_pkg::SZ_HALF: misaligned = ea[0];
            default:          misaligned = |ea[AW-1:0];
        endcase
    end
endmodule

// File: rtl/lsu_lane_sel.sv
// Lane selector.
// Maps the in-word byte offset to the physical byte lane and halfword
// slot under the chosen byte order. Assumes at least four lanes.
module lsu_lane_sel #(
    parameter int XLEN = 32
) (
    input  logic [$clog2(XLEN/8)-1:0]   ofs,
    input  logic                        big,
    output logic [$clog2(XLEN/8)-1:0]   byte_lane,
    output logic [$clog2(XLEN/8)-2:0]   half_slot
);
    localparam int LANES = XLEN / 8;
    localparam int AW    = $clog2(LANES);
    localparam int HW    = AW - 1;

    // Big-endian order counts lanes down from the most significant end.
    always_comb begin
        if (big) begin
            byte_lane = AW'(LANES - 1) - ofs;
            half_slot = HW'(LANES/2 - 1) - ofs[AW-1:1];
        end else begin
            byte_lane = ofs;
            half_slot = ofs[AW-1:1];
        end
    end
endmodule

// File: rtl/lsu_store_lane.sv
// Store lane placer.
// Produces per-lane write enables and lane-positioned write data from the
// source register for byte, halfword and word stores. Lanes that are not
// written carry zeros.
module lsu_store_lane #(
    parameter int XLEN = 32
) (
    input  lsu_pkg::size_e              size,
    input  logic [$clog2(XLEN/8)-1:0]   byte_lane,
    input  logic [$clog2(XLEN/8)-2:0]   half_slot,
    input  logic [XLEN-1:0]             data,
    output logic [XLEN/8-1:0]           be,
    output logic [XLEN-1:0]             wdata
);
    localparam int LANES = XLEN / 8;
    localparam int AW    = $clog2(LANES);
    localparam int HW    = AW - 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic       en;
        logic [7:0] src;

        // Decide whether this lane is written and which source byte feeds it.
        always_comb begin
            unique case (size)
                lsu_pkg::SZ_BYTE: begin
                    en  = (byte_lane == AW'(i));
                    src = data[7:0];
                end
                lsu_pkg::SZ_HALF: begin
                    en  = (half_slot == HW'(i/2));
                    src = data[8*(i%2) +: 8];
                end
                default: begin
                    en  = 1'b1;
                    src = data[8*i +: 8];
                end
            endcase
        end

        assign be[i]          = en;
        assign wdata[8*i +: 8] = en ? src : 8'h00;
    end
endmodule

// File: rtl/lsu_load_lane.sv
// Load lane extractor.
// Picks the addressed byte or halfword out of a returned word and extends
// it to full width, with sign or zero fill.
module lsu_load_lane #(
    parameter int XLEN = 32
) (
    input  lsu_pkg::size_e              size,
    input  logic                        zext,
    input  logic [$clog2(XLEN/8)-1:0]   byte_lane,
    input  logic [$clog2(XLEN/8)-2:0]   half_slot,
    input  logic [XLEN-1:0]             word,
    output logic [XLEN-1:0]             result
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    // Select the addressed pieces of the word.
    always_comb begin
        sel_b = word[{byte_lane, 3'b000} +: 8];
        sel_h = word[{half_slot, 4'b0000} +: 16];
    end

    // Extend the selected piece according to size and fill mode.
    always_comb begin
        unique case (size)
            lsu_pkg::SZ_BYTE: result = {{(XLEN-8){~zext & sel_b[7]}}, sel_b};
            lsu_pkg::SZ_HALF: result = {{(XLEN-16){~zext & sel_h[15]}}, sel_h};
            default:          result = word;
        endcase
    end
endmodule

// File: rtl/lsu_lane_unit.sv
// Load/store lane unit (top).
// Stage 1 registers the memory request (word address, byte enables,
// lane data, strobes, misalignment). Stage 2 carries the load's lane
// context while memory reads. Stage 3 registers the extended load result.
// Assumes memory returns read data exactly one cycle after mem_re.
module lsu_lane_unit #(
    parameter int XLEN = 32,
    parameter int OFFW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_store,
    input  logic [XLEN-1:0]      req_base,
    input  logic [OFFW-1:0]      req_offset,
    input  logic [XLEN-1:0]      req_wdata,
    input  logic [1:0]           req_size,
    input  logic                 req_unsigned,
    input  logic                 req_big_endian,
    output logic [XLEN-1:0]      mem_addr,
    output logic [XLEN/8-1:0]    mem_be,
    output logic [XLEN-1:0]      mem_wdata,
    output logic                 mem_we,
    output logic                 mem_re,
    input  logic [XLEN-1:0]      mem_rdata,
    output logic                 misalign,
    output logic                 ld_valid,
    output logic [XLEN-1:0]      ld_data
);
    localparam int LANES = XLEN / 8;
    localparam int AW    = $clog2(LANES);
    localparam int HW    = AW - 1;

    lsu_pkg::size_e   in_size;
    logic [XLEN-1:0]  ea;
    logic             ea_mis;
    logic [AW-1:0]    st_lane;
    logic [HW-1:0]    st_slot;
    logic [LANES-1:0] st_be;
    logic [XLEN-1:0]  st_data;

    // Lane context of the request now at the memory (stage 1).
    logic [AW-1:0]    s1_ofs;
    lsu_pkg::size_e   s1_size;
    logic             s1_big;
    logic             s1_zext;
    // Lane context of the load whose data is arriving (stage 2).
    logic             s2_valid;
    logic [AW-1:0]    s2_ofs;
    lsu_pkg::size_e   s2_size;
    logic             s2_big;
    logic             s2_zext;
    logic [AW-1:0]    ld_lane;
    logic [HW-1:0]    ld_slot;
    logic [XLEN-1:0]  ld_ext;

    assign in_size = lsu_pkg::size_e'(req_size);

    lsu_agen #(.XLEN(XLEN), .OFFW(OFFW)) u_agen (
        .base       (req_base),
        .offset     (req_offset),
        .size       (in_size),
        .ea         (ea),
        .misaligned (ea_mis)
    );

    lsu_lane_sel #(.XLEN(XLEN)) u_st_sel (
        .ofs       (ea[AW-1:0]),
        .big       (req_big_endian),
        .byte_lane (st_lane),
        .half_slot (st_slot)
    );

    lsu_store_lane #(.XLEN(XLEN)) u_st_lane (
        .size      (in_size),
        .byte_lane (st_lane),
        .half_slot (st_slot),
        .data      (req_wdata),
        .be        (st_be),
        .wdata     (st_data)
    );

    lsu_lane_sel #(.XLEN(XLEN)) u_ld_sel (
        .ofs       (s2_ofs),
        .big       (s2_big),
        .byte_lane (ld_lane),
        .half_slot (ld_slot)
    );

    lsu_load_lane #(.XLEN(XLEN)) u_ld_lane (
        .size      (s2_size),
        .zext      (s2_zext),
        .byte_lane (ld_lane),
        .half_slot (ld_slot),
        .word      (mem_rdata),
        .result    (ld_ext)
    );

    // Stage 1: issue the word request and capture the load lane context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            misalign  <= 1'b0;
            s1_ofs    <= '0;
            s1_size   <= lsu_pkg::SZ_BYTE;
            s1_big    <= 1'b0;
            s1_zext   <= 1'b0;
        end else begin
            mem_we   <= req_valid &  req_store & ~ea_mis;
            mem_re   <= req_valid & ~req_store & ~ea_mis;
            misalign <= req_valid & ea_mis;
            mem_be   <= (req_valid & ~ea_mis) ? st_be : '0;
            if (req_valid) begin
                mem_addr  <= {ea[XLEN-1:AW], {AW{1'b0}}};
                mem_wdata <= req_store ? st_data : '0;
                s1_ofs    <= ea[AW-1:0];
                s1_size   <= in_size;
                s1_big    <= req_big_endian;
                s1_zext   <= req_unsigned;
            end
        end
    end

    // Stage 2: hold the load context during the memory read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_ofs   <= '0;
            s2_size  <= lsu_pkg::SZ_BYTE;
            s2_big   <= 1'b0;
            s2_zext  <= 1'b0;
        end else begin
            s2_valid <= mem_re;
            s2_ofs   <= s1_ofs;
            s2_size  <= s1_size;
            s2_big   <= s1_big;
            s2_zext  <= s1_zext;
        end
    end

    // Stage 3: register the extracted and extended load result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= s2_valid;
            if (s2_valid) begin
                ld_data <= ld_ext;
            end
        end
    end
endmodule

// File: rtl/lsu_lane_unit_chk.sv
// Protocol checker for the load/store lane unit, bound to the top module.
// Relates the request size to the enables one cycle later and the read
// strobe to the load result two cycles later.
module lsu_lane_unit_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       req_size,
    input logic [LANES-1:0] mem_be,
    input logic             mem_we,
    input logic             mem_re,
    input logic             misalign,
    input logic             ld_valid
);
    // R10: a misaligned access enables no lane and strobes nothing.
    a_r10_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == '0 && !mem_we && !mem_re));

    // R7: read and write strobes never overlap.
    a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6: a byte access enables exactly one lane.
    a_r6_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && $past(req_size) == 2'd0) |-> $countones(mem_be) == 1);

    // R6: a halfword access enables one aligned pair of lanes.
    a_r6_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && $past(req_size) == 2'd1) |->
            (mem_be == LANES'(4'b0011) || mem_be == LANES'(4'b1100)));

    // R6: a word access enables every lane.
    a_r6_word_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && $past(req_size) >= 2'd2) |-> mem_be == '1);

    // R11: every read yields a result two cycles later.
    a_r11_read_then_result: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ##2 ld_valid);

    // R11: no result appears without a read two cycles earlier.
    a_r11_result_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_re, 2));
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_size (req_size),
    .mem_be   (mem_be),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .misalign (misalign),
    .ld_valid (ld_valid)
);

// File: tb/lsu_lane_unit_tb.sv
`timescale 1ns/1ps
module lsu_lane_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_unsigned, req_big_endian;
    logic [31:0] req_base, req_wdata;
    logic [15:0] req_offset;
    logic [1:0]  req_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data;
    logic [3:0]  mem_be;
    logic        mem_we, mem_re, misalign, ld_valid;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit mon_on = 0;

    logic [31:0] mem_model [16];
    logic [7:0]  ref_lane  [16][4];

    int          m_due[$];
    logic [31:0] m_addr[$];
    logic [3:0]  m_be[$];
    logic [31:0] m_wd[$];
    logic        m_we[$];
    logic        m_re[$];
    logic        m_mis[$];
    string       m_tag[$];
    int          l_due[$];
    logic [31:0] l_val[$];
    string       l_tag[$];

    always #2.5 clk = ~clk;

    lsu_lane_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_big_endian(req_big_endian),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .misalign(misalign),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Word memory with one-cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we)
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem_model[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
        if (mem_re) mem_rdata <= mem_model[mem_addr[5:2]];
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Compare against expectations on every cycle.
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (m_due.size() > 0 && m_due[0] == cyc) begin
                if (mem_we !== m_we[0] || mem_re !== m_re[0] || misalign !== m_mis[0] ||
                    mem_addr !== m_addr[0] || mem_be !== m_be[0] ||
                    (m_we[0] && mem_wdata !== m_wd[0])) begin
                    errors++;
                    $display("FAIL %s mem: actual we%b re%b mis%b a%h be%b wd%h expected we%b re%b mis%b a%h be%b wd%h",
                             m_tag[0], mem_we, mem_re, misalign, mem_addr, mem_be, mem_wdata,
                             m_we[0], m_re[0], m_mis[0], m_addr[0], m_be[0], m_wd[0]);
                end
                void'(m_due.pop_front()); void'(m_addr.pop_front()); void'(m_be.pop_front());
                void'(m_wd.pop_front()); void'(m_we.pop_front()); void'(m_re.pop_front());
                void'(m_mis.pop_front()); void'(m_tag.pop_front());
            end else if (mem_we || mem_re || misalign) begin
                errors++;
                $display("FAIL R11 idle: actual we%b re%b mis%b expected all 0", mem_we, mem_re, misalign);
            end
            checks++;
            if (l_due.size() > 0 && l_due[0] == cyc) begin
                if (ld_valid !== 1'b1 || ld_data !== l_val[0]) begin
                    errors++;
                    $display("FAIL %s load: actual v%b %h expected v1 %h", l_tag[0], ld_valid, ld_data, l_val[0]);
                end
                void'(l_due.pop_front()); void'(l_val.pop_front()); void'(l_tag.pop_front());
            end else if (ld_valid) begin
                errors++;
                $display("FAIL R11 ld_valid: actual 1 expected 0");
            end
        end
    end

    // Issue one request and record what it must produce, byte by byte.
    task automatic issue(input bit st, input logic [31:0] base, input logic [15:0] off,
                         input logic [31:0] data, input logic [1:0] sz, input bit uns,
                         input bit big, input string tag);
        logic [31:0] ea, wd, val;
        logic [3:0]  be;
        int n, a0, w, lane, sh;
        bit mis;
        ea  = base + {{16{off[15]}}, off};
        n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        a0  = int'(ea[1:0]);
        mis = (a0 % n) != 0;
        w   = int'(ea[5:2]);
        be = '0; wd = '0; val = '0;
        if (!mis) begin
            for (int j = 0; j < n; j++) begin
                lane = big ? 3 - ((a0 + j) % 4) : (a0 + j) % 4;
                sh   = big ? 8 * (n - 1 - j) : 8 * j;
                be[lane] = 1'b1;
                if (st) begin
                    wd[8*lane +: 8] = data[sh +: 8];
                    ref_lane[w][lane] = data[sh +: 8];
                end else begin
                    val[sh +: 8] = ref_lane[w][lane];
                end
            end
            if (!st && n < 4 && !uns && val[8*n-1]) val = val | ~((32'h1 << (8*n)) - 32'h1);
        end
        m_due.push_back(cyc + 1); m_addr.push_back({ea[31:2], 2'b00}); m_be.push_back(be);
        m_wd.push_back(wd); m_we.push_back(st && !mis); m_re.push_back(!st && !mis);
        m_mis.push_back(mis); m_tag.push_back(tag);
        if (!st && !mis) begin
            l_due.push_back(cyc + 3); l_val.push_back(val); l_tag.push_back(tag);
        end
        req_valid = 1'b1; req_store = st; req_base = base; req_offset = off;
        req_wdata = data; req_size = sz; req_unsigned = uns; req_big_endian = big;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507);
            for (int k = 0; k < 4; k++) ref_lane[i][k] = mem_model[i][8*k +: 8];
        end
        mem_rdata = '0;
        rst_n = 1'b0;
        req_valid = 1'b1; req_store = 1'b1; req_base = 32'h10; req_offset = '0;
        req_wdata = 32'hFFFF_FFFF; req_size = 2'd2; req_unsigned = 1'b0; req_big_endian = 1'b0;
        idle(4);
        // R1: outputs stay zero under reset despite a live request.
        checks++;
        if (mem_addr !== 0 || mem_be !== 0 || mem_wdata !== 0 || mem_we || mem_re ||
            misalign || ld_valid || ld_data !== 0) begin
            errors++;
            $display("FAIL R1 reset: actual a%h be%b we%b re%b ld%b expected all zero",
                     mem_addr, mem_be, mem_we, mem_re, ld_valid);
        end
        req_valid = 1'b0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // R2: negative displacement, then a positive one that wraps.
        issue(1, 32'h0000_0020, 16'hFFF0, 32'h1122_3344, 2'd2, 0, 0, "R2");
        issue(0, 32'hFFFF_8020, 16'h7FF0, 32'h0, 2'd2, 0, 0, "R2");
        // R3: little-endian byte loads, back to back (R11).
        for (int k = 0; k < 4; k++) issue(0, 32'h10, 16'(k), 0, 2'd0, 1, 0, "R3");
        // R4: big-endian byte loads.
        for (int k = 0; k < 4; k++) issue(0, 32'h10, 16'(k), 0, 2'd0, 1, 1, "R4");
        idle(3);
        // R8 / R9 / R5: sign and zero fill, halfword placement.
        issue(1, 32'h14, 16'h0, 32'h80FF_7F01, 2'd2, 0, 0, "R7");
        issue(0, 32'h14, 16'h0, 0, 2'd0, 0, 1, "R8");
        issue(0, 32'h14, 16'h0, 0, 2'd0, 1, 1, "R9");
        issue(0, 32'h14, 16'h1, 0, 2'd0, 0, 0, "R8");
        issue(0, 32'h14, 16'h0, 0, 2'd1, 0, 0, "R5");
        issue(0, 32'h14, 16'h2, 0, 2'd1, 0, 0, "R8");
        issue(0, 32'h14, 16'h2, 0, 2'd1, 1, 0, "R9");
        issue(0, 32'h14, 16'h0, 0, 2'd1, 0, 1, "R5");
        issue(0, 32'h14, 16'h2, 0, 2'd1, 1, 1, "R5");
        idle(2);
        // R7: partial stores leave neighbours intact.
        issue(1, 32'h10, 16'h1, 32'h1234_56AB, 2'd0, 0, 0, "R7");
        issue(0, 32'h10, 16'h0, 0, 2'd2, 0, 0, "R7");
        issue(1, 32'h10, 16'h0, 32'h0000_00CD, 2'd0, 0, 1, "R4");
        issue(1, 32'h10, 16'h2, 32'hFFFF_BEEF, 2'd1, 0, 1, "R5");
        issue(0, 32'h10, 16'h0, 0, 2'd2, 0, 0, "R7");
        issue(1, 32'h18, 16'h2, 32'h0000_CAFE, 2'd1, 0, 0, "R6");
        issue(1, 32'h18, 16'h3, 32'h0000_0077, 2'd0, 0, 1, "R6");
        issue(0, 32'h18, 16'h0, 0, 2'd2, 0, 1, "R9");
        issue(1, 32'h1C, 16'h0, 32'hDEAD_BEEF, 2'd3, 0, 1, "R6");
        issue(0, 32'h1C, 16'h0, 0, 2'd3, 0, 0, "R6");
        idle(3);
        // R10: misaligned requests touch nothing.
        issue(0, 32'h10, 16'h1, 0, 2'd1, 0, 0, "R10");
        issue(1, 32'h10, 16'h2, 32'hFFFF_FFFF, 2'd2, 0, 0, "R10");
        issue(1, 32'h10, 16'h3, 32'hFFFF_FFFF, 2'd1, 0, 1, "R10");
        issue(0, 32'h13, 16'h0, 0, 2'd2, 1, 1, "R10");
        issue(0, 32'h10, 16'h0, 0, 2'd2, 0, 0, "R10");
        idle(6);

        checks++;
        if (m_due.size() != 0 || l_due.size() != 0) begin
            errors++;
            $display("FAIL R11 drain: actual %0d/%0d pending expected 0/0", m_due.size(), l_due.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule